// File: doc/BRIEF.md
# Discharge Path Protection Controller

This block sequences the discharge-enable output of a two-cell battery protector. Comparator flags arrive from the analog front end: one under-voltage flag per cell, an over-current flag, a short-circuit flag, and a flag showing the negative sense node has fallen below the standby-release level. A charger-present flag, the over-charge state of the charge path, a test-mode strap and a prescaler tick also come in. The block decides when to cut the discharge switch and when to let it close again. It also decides when to enter a low-power standby, and which internal pull (none, to supply, or to ground) is applied to the sense node.

Every fault must persist for a programmed number of prescaler ticks before it latches. The first fault to latch owns the output until it is released. Under-voltage faults pull the sense node toward supply and normally enter standby, which only a charger can release. Current faults pull the sense node toward ground and never enter standby. Test mode divides the counter-based delays by a power of two so that production test runs quickly. The short-circuit delay is exempt from this division.

All control pins are plain levels. The block has no streamed data interface, so it has no valid/ready handshake.

Top module: `dis_guard`

## Requirements
- R1: After reset, `dsg_en` is 1, `standby` is 0 and `pull_sel` is 2'b00 (no pull). The `pull_sel` encoding is 2'b00 none, 2'b01 to supply, 2'b10 to ground.
- R2: When either cell flag is held for OD_DET_TICKS ticks while no fault is latched, `dsg_en` goes to 0, `standby` goes to 1 and `pull_sel` goes to 2'b01. A flag that drops before the count completes leaves the outputs unchanged.
- R3: Standby clears only in a cycle where `charger_on` and `sense_at_release` are both 1. Clearing standby does not by itself raise `dsg_en`.
- R4: Under-voltage release requires three things: standby clear, `charger_on` at 1, and both cell flags at 0. After these hold for OD_REL_TICKS ticks, `dsg_en` returns to 1 and `pull_sel` returns to 2'b00.
- R5: `cur_over` held for OC_DET_TICKS ticks drives `dsg_en` to 0 and `pull_sel` to 2'b10, and `standby` stays 0.
- R6: `cur_short` held for SC_DET_TICKS ticks (fewer than OC_DET_TICKS) has the same effect as R5.
- R7: Once a current fault has latched, it releases when both `cur_over` and `cur_short` stay 0 for OC_REL_TICKS ticks. `dsg_en` then returns to 1 and `pull_sel` to 2'b00.
- R8: If `charge_blocked` is 1 when an under-voltage fault latches, `standby` stays 0 while `pull_sel` still goes to 2'b01.
- R9: The under-voltage, over-current and short-circuit detectors count in parallel. The first to complete latches, and the other detectors restart from zero only after the block is back in normal operation. If both kinds complete in the same cycle, the current fault wins.
- R10: With `test_fast` at 1, the OD/OC detect and release delays become max(1, ticks >> TEST_SHIFT). The short-circuit delay is not changed.
- R11: Every input passes through a two-flop synchroniser. A delay of L ticks therefore changes the outputs on the (L+3)-th rising edge after the input changes, when a tick is present every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cell_a_low | input | 1 | Cell A under-voltage flag |
| cell_b_low | input | 1 | Cell B under-voltage flag |
| cur_over | input | 1 | Sense node above over-current level |
| cur_short | input | 1 | Sense node above short-circuit level |
| sense_at_release | input | 1 | Sense node below standby-release level |
| charger_on | input | 1 | Charger connected |
| charge_blocked | input | 1 | Charge path is in over-charge state |
| test_fast | input | 1 | Shorten counter-based delays |
| tick | input | 1 | Prescaler tick that advances delay counters |
| dsg_en | output | 1 | Discharge switch enable |
| standby | output | 1 | Low-power standby request |
| pull_sel | output | 2 | Sense-node pull select (00 none, 01 supply, 10 ground) |

## Verification
The stimulus includes an under-voltage pulse shorter than its delay and one held past it. This shows that the detector filters on persistence rather than on edges. Standby exit is driven first with the charger alone and then with the charger plus the release level, and the sequence is repeated with over-charge active, so the standby decision is exercised separately from the release counter. Overlapping faults are applied staggered and in a same-cycle tie, which shows that the first latch wins and the other detectors restart. Test mode is run against both current detectors, which separates the scaled delays from the fixed short-circuit delay.

// File: rtl/dg_pkg.sv
package dg_pkg;

  typedef enum logic [1:0] {
    PULL_NONE   = 2'b00,
    PULL_SUPPLY = 2'b01,
    PULL_GROUND = 2'b10
  } pull_e;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'b00,
    MODE_UNDER   = 2'b01,
    MODE_CURRENT = 2'b10
  } mode_e;

  function automatic int dg_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // test-mode delay: divided by 2**s, never below one tick
  function automatic int dg_scaled(input int v, input int s);
    return ((v >> s) > 0) ? (v >> s) : 1;
  endfunction

endpackage

// File: rtl/dg_sync.sv
module dg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d[i]};
    end
    assign q[i] = sh[STAGES-1];
  end

endmodule

// File: rtl/dg_persist.sv
module dg_persist #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cond,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr || !cond)      cnt <= '0;
    else if (tick && cnt < limit) cnt <= cnt + CW'(1);
  end

  assign done = cond && !clr && (cnt >= limit);

  // R2: a dropped condition restarts the count
  a_r2_restart_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (clr || !cond) |=> (cnt == '0));

  // R11: the count only moves on a tick
  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (cond && !clr && !tick) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/dis_guard.sv
module dis_guard
  import dg_pkg::*;
#(
  parameter int OD_DET_TICKS = 16,
  parameter int OD_REL_TICKS = 8,
  parameter int OC_DET_TICKS = 12,
  parameter int OC_REL_TICKS = 6,
  parameter int SC_DET_TICKS = 3,
  parameter int TEST_SHIFT   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cell_a_low,
  input  logic       cell_b_low,
  input  logic       cur_over,
  input  logic       cur_short,
  input  logic       sense_at_release,
  input  logic       charger_on,
  input  logic       charge_blocked,
  input  logic       test_fast,
  input  logic       tick,
  output logic       dsg_en,
  output logic       standby,
  output logic [1:0] pull_sel
);

  localparam int MAXP = dg_max(dg_max(dg_max(OD_DET_TICKS, OD_REL_TICKS),
                                      dg_max(OC_DET_TICKS, OC_REL_TICKS)),
                               SC_DET_TICKS);
  localparam int CW    = $clog2(MAXP + 1);
  localparam int NSYNC = 9;

  localparam int OD_DET_F = dg_scaled(OD_DET_TICKS, TEST_SHIFT);
  localparam int OD_REL_F = dg_scaled(OD_REL_TICKS, TEST_SHIFT);
  localparam int OC_DET_F = dg_scaled(OC_DET_TICKS, TEST_SHIFT);
  localparam int OC_REL_F = dg_scaled(OC_REL_TICKS, TEST_SHIFT);

  // synchronised inputs
  logic [NSYNC-1:0] raw_in, syn;
  logic a_s, b_s, oc_s, sc_s, srel_s, chg_s, ochg_s, test_s, tick_s;

  assign raw_in = {tick, test_fast, charge_blocked, charger_on, sense_at_release,
                   cur_short, cur_over, cell_b_low, cell_a_low};

  dg_sync #(.W(NSYNC), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  assign {tick_s, test_s, ochg_s, chg_s, srel_s, sc_s, oc_s, b_s, a_s} = syn;

  // state
  mode_e mode_q;
  logic  dsg_q, stby_q;
  pull_e pull_q;

  // delay limits
  logic [CW-1:0] od_det_lim, od_rel_lim, oc_det_lim, oc_rel_lim, sc_det_lim;
  assign od_det_lim = test_s ? CW'(OD_DET_F) : CW'(OD_DET_TICKS);
  assign od_rel_lim = test_s ? CW'(OD_REL_F) : CW'(OD_REL_TICKS);
  assign oc_det_lim = test_s ? CW'(OC_DET_F) : CW'(OC_DET_TICKS);
  assign oc_rel_lim = test_s ? CW'(OC_REL_F) : CW'(OC_REL_TICKS);
  assign sc_det_lim = CW'(SC_DET_TICKS);

  logic in_run, in_under, in_cur;
  assign in_run   = (mode_q == MODE_RUN);
  assign in_under = (mode_q == MODE_UNDER);
  assign in_cur   = (mode_q == MODE_CURRENT);

  logic od_done, odr_done, oc_done, sc_done, ocr_done;

  dg_persist #(.CW(CW)) u_od_det (
    .clk(clk), .rst_n(rst_n), .clr(!in_run), .cond(a_s || b_s),
    .tick(tick_s), .limit(od_det_lim), .done(od_done)
  );

  dg_persist #(.CW(CW)) u_od_rel (
    .clk(clk), .rst_n(rst_n), .clr(!in_under || stby_q),
    .cond(chg_s && !a_s && !b_s),
    .tick(tick_s), .limit(od_rel_lim), .done(odr_done)
  );

  dg_persist #(.CW(CW)) u_oc_det (
    .clk(clk), .rst_n(rst_n), .clr(!in_run), .cond(oc_s),
    .tick(tick_s), .limit(oc_det_lim), .done(oc_done)
  );

  dg_persist #(.CW(CW)) u_sc_det (
    .clk(clk), .rst_n(rst_n), .clr(!in_run), .cond(sc_s),
    .tick(tick_s), .limit(sc_det_lim), .done(sc_done)
  );

  dg_persist #(.CW(CW)) u_oc_rel (
    .clk(clk), .rst_n(rst_n), .clr(!in_cur), .cond(!oc_s && !sc_s),
    .tick(tick_s), .limit(oc_rel_lim), .done(ocr_done)
  );

  // sequencing: first completed detector owns the output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      dsg_q  <= 1'b1;
      stby_q <= 1'b0;
      pull_q <= PULL_NONE;
    end else begin
      case (mode_q)
        MODE_RUN: begin
          if (oc_done || sc_done) begin
            mode_q <= MODE_CURRENT;
            dsg_q  <= 1'b0;
            pull_q <= PULL_GROUND;
          end else if (od_done) begin
            mode_q <= MODE_UNDER;
            dsg_q  <= 1'b0;
            pull_q <= PULL_SUPPLY;
            stby_q <= !ochg_s;
          end
        end
        MODE_UNDER: begin
          if (stby_q) begin
            if (chg_s && srel_s) stby_q <= 1'b0;
          end else if (odr_done) begin
            mode_q <= MODE_RUN;
            dsg_q  <= 1'b1;
            pull_q <= PULL_NONE;
          end
        end
        MODE_CURRENT: begin
          if (ocr_done) begin
            mode_q <= MODE_RUN;
            dsg_q  <= 1'b1;
            pull_q <= PULL_NONE;
          end
        end
        default: begin
          mode_q <= MODE_RUN;
          dsg_q  <= 1'b1;
          stby_q <= 1'b0;
          pull_q <= PULL_NONE;
        end
      endcase
    end
  end

  assign dsg_en   = dsg_q;
  assign standby  = stby_q;
  assign pull_sel = pull_q;

  // R1: an enabled discharge path never has a pull applied
  a_r1_enable_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
    dsg_q |-> (pull_q == PULL_NONE));

  // R3: standby leaves only with charger and release level together
  a_r3_standby_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stby_q) |-> $past(chg_s && srel_s));

  // R8: standby is never entered while over-charge is active
  a_r8_no_standby_overcharge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stby_q) |-> !$past(ochg_s));

  // R5: a current fault never coexists with standby
  a_r5_ground_no_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_q == PULL_GROUND) |-> !stby_q);

  // R9: no direct hand-over from one latched fault to the other
  a_r9_no_direct_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_q == PULL_SUPPLY) |=> (pull_q != PULL_GROUND));

  // R4: discharge re-enables only from outside standby
  a_r4_release_after_standby: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dsg_q) |-> !$past(stby_q));

endmodule

// File: tb/tb_dis_guard.sv
module tb_dis_guard;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic od_a = 0, od_b = 0, ocur = 0, shrt = 0, srel = 0, chg = 0, ochg = 0, tst = 0, tick = 1;
  logic dsg_en, standby;
  logic [1:0] pull_sel;

  always #2 clk = ~clk;  // 250 MHz

  dis_guard dut (
    .clk(clk), .rst_n(rst_n),
    .cell_a_low(od_a), .cell_b_low(od_b),
    .cur_over(ocur), .cur_short(shrt),
    .sense_at_release(srel), .charger_on(chg),
    .charge_blocked(ochg), .test_fast(tst), .tick(tick),
    .dsg_en(dsg_en), .standby(standby), .pull_sel(pull_sel)
  );

  typedef struct {
    int         cyc;
    logic       d;
    logic       s;
    logic [1:0] p;
    string      tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int total = 0;
  int fails = 0;
  bit done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items at their cycle
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0 && q[0].cyc <= cyc) begin
      e = q.pop_front();
      total++;
      if (dsg_en !== e.d || standby !== e.s || pull_sel !== e.p) begin
        fails++;
        $display("FAIL %s: got dsg=%0b stby=%0b pull=%0d, expected dsg=%0b stby=%0b pull=%0d",
                 e.tag, dsg_en, standby, pull_sel, e.d, e.s, e.p);
      end
    end
  end

  task automatic expect_at(input int off, input logic d, input logic s,
                           input logic [1:0] p, input string tag);
    exp_t e;
    e.cyc = cyc + off; e.d = d; e.s = s; e.p = p; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain;
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic recover;
    od_a = 0; od_b = 0; ocur = 0; shrt = 0; ochg = 0;
    chg = 1; srel = 1;
    step(40);
    chg = 0; srel = 0;
    step(5);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    step(4);
    rst_n = 1'b1;
    step(1);
    expect_at(1, 1, 0, 2'b00, "R1 reset state");
    drain;
    step(4);

    // R2: short pulse filtered
    od_a = 1;
    expect_at(20, 1, 0, 2'b00, "R2 short pulse ignored");
    step(10); od_a = 0;
    drain; step(3);

    // R2/R11: held flag trips at L+3
    od_b = 1;
    expect_at(18, 1, 0, 2'b00, "R11 one edge before trip");
    expect_at(19, 0, 1, 2'b01, "R2 under-voltage latched");
    drain;

    // R3: charger alone does not leave standby
    chg = 1;
    expect_at(6, 0, 1, 2'b01, "R3 charger alone keeps standby");
    drain;
    srel = 1;
    expect_at(2, 0, 1, 2'b01, "R3 before exit");
    expect_at(3, 0, 0, 2'b01, "R3 standby cleared, still disabled");
    drain;
    od_b = 0;
    expect_at(10, 0, 0, 2'b01, "R4 before release");
    expect_at(11, 1, 0, 2'b00, "R4 released");
    drain;
    chg = 0; srel = 0; step(5);

    // R8: over-charge suppresses standby
    ochg = 1; step(4);
    od_a = 1;
    expect_at(18, 1, 0, 2'b00, "R8 before trip");
    expect_at(19, 0, 0, 2'b01, "R8 no standby, pull to supply");
    drain;
    chg = 1; od_a = 0;
    expect_at(11, 1, 0, 2'b00, "R4 release without standby");
    drain;
    ochg = 0; chg = 0; step(5);

    // R5 / R7
    ocur = 1;
    expect_at(14, 1, 0, 2'b00, "R5 before trip");
    expect_at(15, 0, 0, 2'b10, "R5 over-current latched");
    drain;
    ocur = 0;
    expect_at(8, 0, 0, 2'b10, "R7 before release");
    expect_at(9, 1, 0, 2'b00, "R7 current release");
    drain; step(3);

    // R6
    shrt = 1;
    expect_at(5, 1, 0, 2'b00, "R6 before trip");
    expect_at(6, 0, 0, 2'b10, "R6 short latched");
    drain;
    shrt = 0;
    expect_at(9, 1, 0, 2'b00, "R7 short release");
    drain; step(3);

    // R9: staggered, current first
    ocur = 1;
    expect_at(15, 0, 0, 2'b10, "R9 current latched first");
    expect_at(25, 0, 0, 2'b10, "R9 under-voltage suppressed");
    step(2); od_a = 1;
    drain;
    ocur = 0;
    expect_at(9, 1, 0, 2'b00, "R9 back to normal");
    expect_at(25, 1, 0, 2'b00, "R9 detector restarted");
    expect_at(26, 0, 1, 2'b01, "R9 under-voltage after restart");
    drain;
    recover;

    // R9: same-cycle tie goes to current fault
    od_a = 1;
    expect_at(19, 0, 0, 2'b10, "R9 tie favours current");
    step(4); ocur = 1;
    drain;
    recover;

    // R10: test mode
    tst = 1; step(4);
    ocur = 1;
    expect_at(5, 1, 0, 2'b00, "R10 scaled oc before");
    expect_at(6, 0, 0, 2'b10, "R10 scaled oc trip");
    drain;
    ocur = 0;
    expect_at(3, 0, 0, 2'b10, "R10 scaled release before");
    expect_at(4, 1, 0, 2'b00, "R10 scaled release");
    drain;
    shrt = 1;
    expect_at(5, 1, 0, 2'b00, "R10 short delay not shortened");
    expect_at(6, 0, 0, 2'b10, "R6 short trip in test mode");
    drain;
    shrt = 0;
    expect_at(4, 1, 0, 2'b00, "R10 short release scaled");
    drain;
    od_a = 1;
    expect_at(6, 1, 0, 2'b00, "R10 scaled od before");
    expect_at(7, 0, 1, 2'b01, "R10 scaled od trip");
    drain;
    recover;
    tst = 0;
    step(5);

    done_flag = 1;
    summary;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary;
      $finish;
    end
  end

endmodule